// File: doc/BRIEF.md
# Dual-Clock FIFO with Retransmit

This block is a first-in first-out buffer whose write side and read side each run on their own clock, and the two clocks may be unrelated. The write side accepts a word on any write-clock edge where the port is enabled and selected and the buffer has room. It reports room through an input-ready flag and an active-low almost-full flag, both registered on the write clock. The read side always holds the oldest word in an output register and reports it through an output-ready flag. A read removes that word and loads the next one on the same edge. An active-low almost-empty flag on the read clock reports a low fill level.

The two thresholds arrive as plain inputs, one on each side, so that a separate loader can program them. Pointers cross between the clock domains as Gray code through two-flop synchronizers. Depth must be a power of two.

A retransmit mode lets the reader mark the word now at the output and later return to it. While the mode is active, the marked location and everything after it are protected: the writer stops when it reaches the mark. Leaving the mode releases that space again, one location per read-clock cycle.

Top module: `rtx_fifo`

## Requirements
- R1: While `rst_n` is low, `in_rdy` is 0, `out_rdy` is 0, `alm_empty_n` is 0 and `alm_full_n` is 1. `in_rdy` becomes 1 on the first write-clock edge after `rst_n` goes high.
- R2: After a word is written into an empty buffer, `out_rdy` is still 0 after the second rising read-clock edge that follows the write edge. It is 1 after the third, with that word on `r_data`.
- R3: While `out_rdy` is 1, `r_data` holds the oldest unread word. A read (`r_en`=1, `r_cs_n`=0) removes it, and on the same edge the next word appears, or `out_rdy` falls if none is stored. Words leave in the order they were written.
- R4: The buffer holds DEPTH words, counting the word in the output register. `in_rdy` is 0 once DEPTH words are stored, and writes offered while `in_rdy` is 0 are dropped.
- R5: A write needs `w_en`=1 and `w_cs_n`=0 on a write-clock edge. A read needs `r_en`=1 and `r_cs_n`=0 on a read-clock edge. Any other combination leaves the contents and `r_data` unchanged.
- R6: Once the pointers have settled, `alm_empty_n` is 0 exactly when the stored word count (including the output word) is at most `ae_ofs`.
- R7: Once the pointers have settled, `alm_full_n` is 0 exactly when DEPTH minus the stored word count is at most `af_ofs`.
- R8: A read-clock edge with `rt_mode`=1 and `out_rdy`=1 enters retransmit mode and marks the word at the output. While `rt_mode` stays 1, later edges do not move the mark.
- R9: In retransmit mode, a read-clock edge with `rd_mark`=1 puts the marked word on `r_data` and sets `out_rdy` to 1. Following reads continue with the words after the mark. `rd_mark` takes priority over a read on the same edge.
- R10: In retransmit mode, writes stop when they would reach the marked location, so that `in_rdy` falls. The marked word and the words after it stay readable, however many times they are re-read.
- R11: A read-clock edge with `rt_mode`=0 leaves retransmit mode. After that, `rd_mark` has no effect, and the space held by the mark is returned to the writer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wclk | input | 1 | Write clock |
| w_en | input | 1 | Write enable, active high |
| w_cs_n | input | 1 | Write port select, active low |
| w_data | input | WIDTH | Word to store |
| af_ofs | input | log2(DEPTH) | Almost-full threshold on free locations |
| in_rdy | output | 1 | Room available; writes accepted |
| alm_full_n | output | 1 | Low when free locations are at most `af_ofs` |
| rclk | input | 1 | Read clock |
| r_en | input | 1 | Read enable, active high |
| r_cs_n | input | 1 | Read port select, active low |
| rt_mode | input | 1 | Enter (1) or leave (0) retransmit mode |
| rd_mark | input | 1 | Return the read pointer to the mark |
| ae_ofs | input | log2(DEPTH) | Almost-empty threshold on stored words |
| r_data | output | WIDTH | Output register holding the oldest word |
| out_rdy | output | 1 | `r_data` holds a valid word |
| alm_empty_n | output | 1 | Low when stored words are at most `ae_ofs` |

## Verification
The results that stay inside one domain are checked at the next falling edge of their own clock:
- `r_data` and `out_rdy` change on the same read edge as a read or a mark reload.
- `in_rdy` is registered on the write edge that stores the word.

Output-ready after a write into an empty buffer is due on the third read edge, so the bench counts read edges from the write edge. It samples one nanosecond after the second and third of them.

Results that depend on the far domain are checked only after a settling window of sixteen read cycles or more, which covers both synchronizers and the one-step-per-cycle release pointer. These are the almost flags, the room that reads free, and the room returned after leaving retransmit mode.

// File: rtl/rtx_fifo.sv
module rtx_fifo #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             rst_n,
  input  logic             wclk,
  input  logic             w_en,
  input  logic             w_cs_n,
  input  logic [WIDTH-1:0] w_data,
  input  logic [AW-1:0]    af_ofs,
  output logic             in_rdy,
  output logic             alm_full_n,
  input  logic             rclk,
  input  logic             r_en,
  input  logic             r_cs_n,
  input  logic             rt_mode,
  input  logic             rd_mark,
  input  logic [AW-1:0]    ae_ofs,
  output logic [WIDTH-1:0] r_data,
  output logic             out_rdy,
  output logic             alm_empty_n
);
  localparam logic [PW-1:0] CAP = PW'(DEPTH);

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [WIDTH-1:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wptr, wgray, lq1, lq2, lim_w, wptr_nx, used_nx, free_nx;
  logic          push;

  assign push    = w_en & ~w_cs_n & in_rdy;
  assign wptr_nx = wptr + PW'(push);
  assign lim_w   = g2b(lq2);
  assign used_nx = wptr_nx - lim_w;
  assign free_nx = CAP - used_nx;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr       <= '0;
      wgray      <= '0;
      lq1        <= '0;
      lq2        <= '0;
      in_rdy     <= 1'b0;
      alm_full_n <= 1'b1;
    end else begin
      wptr       <= wptr_nx;
      wgray      <= b2g(wptr_nx);
      lq1        <= lgray;
      lq2        <= lq1;
      in_rdy     <= used_nx != CAP;
      alm_full_n <= free_nx > {1'b0, af_ofs};
    end
  end

  always_ff @(posedge wclk) begin
    if (push) mem[wptr[AW-1:0]] <= w_data;
  end

  // read domain
  logic [PW-1:0] rptr, mark, lim, lgray, wq1, wq2, wsync, head;
  logic [PW-1:0] rptr_nx, raddr, head_nx, cnt_nx, lim_tgt, lim_nx;
  logic          in_rt, pop, reload, avail, fetch, or_nx;

  assign wsync   = g2b(wq2);
  assign head    = rptr - PW'(out_rdy);
  assign avail   = rptr != wsync;
  assign pop     = r_en & ~r_cs_n & out_rdy;
  assign reload  = in_rt & rd_mark;
  assign lim_tgt = in_rt ? mark : head;
  assign lim_nx  = (lim != lim_tgt) ? lim + PW'(1) : lim;

  always_comb begin
    rptr_nx = rptr;
    or_nx   = out_rdy;
    raddr   = rptr;
    fetch   = 1'b0;
    if (reload) begin
      raddr   = mark;
      rptr_nx = mark + PW'(1);
      or_nx   = 1'b1;
      fetch   = 1'b1;
    end else if ((!out_rdy || pop) && avail) begin
      rptr_nx = rptr + PW'(1);
      or_nx   = 1'b1;
      fetch   = 1'b1;
    end else if (pop) begin
      or_nx = 1'b0;
    end
  end

  assign head_nx = rptr_nx - PW'(or_nx);
  assign cnt_nx  = g2b(wq1) - head_nx;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr        <= '0;
      mark        <= '0;
      lim         <= '0;
      lgray       <= '0;
      wq1         <= '0;
      wq2         <= '0;
      in_rt       <= 1'b0;
      out_rdy     <= 1'b0;
      alm_empty_n <= 1'b0;
    end else begin
      wq1         <= wgray;
      wq2         <= wq1;
      rptr        <= rptr_nx;
      out_rdy     <= or_nx;
      lim         <= lim_nx;
      lgray       <= b2g(lim_nx);
      alm_empty_n <= cnt_nx > {1'b0, ae_ofs};
      in_rt       <= rt_mode & (in_rt | out_rdy);
      if (rt_mode && !in_rt && out_rdy) mark <= head;
    end
  end

  always_ff @(posedge rclk) begin
    if (fetch) r_data <= mem[raddr[AW-1:0]];
  end
endmodule

// File: rtl/rtx_fifo_chk.sv
module rtx_fifo_chk #(
  parameter int DEPTH = 2048,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input logic          rst_n,
  input logic          wclk,
  input logic          rclk,
  input logic          in_rdy,
  input logic          out_rdy,
  input logic          in_rt,
  input logic          rt_mode,
  input logic          rd_mark,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] lim_w,
  input logic [PW-1:0] rptr,
  input logic [PW-1:0] mark,
  input logic [PW-1:0] lim,
  input logic [PW-1:0] wsync,
  input logic [PW-1:0] head
);
  always @(posedge wclk) if (!rst_n) a_r1_ir_low_in_reset: assert (!in_rdy);
  always @(posedge rclk) if (!rst_n) a_r1_or_low_in_reset: assert (!out_rdy);

  a_r4_hold_when_full: assert property (@(posedge wclk) disable iff (!rst_n)
    !in_rdy |=> wptr == $past(wptr));

  a_r10_fill_bound: assert property (@(posedge wclk) disable iff (!rst_n)
    (wptr - lim_w) <= PW'(DEPTH));

  a_r6_count_bound: assert property (@(posedge rclk) disable iff (!rst_n)
    (wsync - head) <= PW'(DEPTH));

  a_r8_mark_held: assert property (@(posedge rclk) disable iff (!rst_n)
    in_rt && rt_mode |=> $stable(mark));

  a_r9_reload: assert property (@(posedge rclk) disable iff (!rst_n)
    in_rt && rd_mark |=> out_rdy && (rptr == PW'($past(mark) + PW'(1))));

  a_r11_release_step: assert property (@(posedge rclk) disable iff (!rst_n)
    (lim - $past(lim)) <= PW'(1));
endmodule

bind rtx_fifo rtx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .rst_n(rst_n), .wclk(wclk), .rclk(rclk), .in_rdy(in_rdy), .out_rdy(out_rdy),
  .in_rt(in_rt), .rt_mode(rt_mode), .rd_mark(rd_mark), .wptr(wptr), .lim_w(lim_w),
  .rptr(rptr), .mark(mark), .lim(lim), .wsync(wsync), .head(head)
);

// File: tb/sim_rtx_fifo.sv
`timescale 1ns/1ps
module sim_rtx_fifo;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int WIDTH = 16;
  localparam int DEPTH = 8;
  localparam int AW = $clog2(DEPTH);
  localparam int XTH = 3;
  localparam int YTH = 2;

  logic rst_n, wclk, rclk;
  logic w_en, w_cs_n, r_en, r_cs_n, rt_mode, rd_mark;
  logic [WIDTH-1:0] w_data, r_data;
  logic in_rdy, alm_full_n, out_rdy, alm_empty_n;
  int tests = 0, fails = 0;

  rtx_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u0 (
    .rst_n(rst_n), .wclk(wclk), .w_en(w_en), .w_cs_n(w_cs_n), .w_data(w_data),
    .af_ofs(AW'(YTH)), .in_rdy(in_rdy), .alm_full_n(alm_full_n),
    .rclk(rclk), .r_en(r_en), .r_cs_n(r_cs_n), .rt_mode(rt_mode), .rd_mark(rd_mark),
    .ae_ofs(AW'(XTH)), .r_data(r_data), .out_rdy(out_rdy), .alm_empty_n(alm_empty_n)
  );

  initial wclk = 0;
  always #(CLK_PERIOD/2) wclk = ~wclk;
  initial begin
    rclk = 0;
    #3;
    forever #(RCLK_PERIOD/2) rclk = ~rclk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (5) @(negedge rclk);
    chk("R1 in_rdy in reset", 32'(in_rdy), 0);
    chk("R1 out_rdy in reset", 32'(out_rdy), 0);
    chk("R1 alm_empty_n in reset", 32'(alm_empty_n), 0);
    chk("R1 alm_full_n in reset", 32'(alm_full_n), 1);
    @(posedge rclk);
    #2 rst_n = 1;
    @(posedge wclk);
    @(negedge wclk);
    chk("R1 in_rdy after release", 32'(in_rdy), 1);
  endtask

  task automatic wr_try(input logic [WIDTH-1:0] d, input logic en, input logic csn);
    @(negedge wclk);
    w_en = en; w_cs_n = csn; w_data = d;
    @(negedge wclk);
    w_en = 0; w_cs_n = 0;
  endtask

  task automatic rd_try(input logic en, input logic csn);
    @(negedge rclk);
    r_en = en; r_cs_n = csn;
    @(negedge rclk);
    r_en = 0; r_cs_n = 0;
  endtask

  task automatic settle();
    repeat (16) @(negedge rclk);
    @(negedge wclk);
  endtask

  task automatic set_rt(input logic v);
    @(negedge rclk);
    rt_mode = v;
    @(negedge rclk);
  endtask

  task automatic mark_pulse();
    @(negedge rclk);
    rd_mark = 1;
    @(negedge rclk);
    rd_mark = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; w_en = 0; w_cs_n = 0; w_data = '0;
    r_en = 0; r_cs_n = 0; rt_mode = 0; rd_mark = 0;
    do_reset();

    // R5: unqualified writes store nothing
    wr_try(16'h55, 1, 1);
    wr_try(16'h56, 0, 0);
    settle();
    chk("R5 no word after deselected write", 32'(out_rdy), 0);
    chk("R5 empty flag after ignored writes", 32'(alm_empty_n), 0);

    // fill sweep
    for (int k = 1; k <= DEPTH; k++) begin
      if (k == 1) begin
        @(negedge wclk);
        w_en = 1; w_data = 16'd101;
        @(posedge wclk);
        fork begin @(negedge wclk); w_en = 0; end join_none
        @(posedge rclk); @(posedge rclk);
        #1 chk("R2 out_rdy after 2nd edge", 32'(out_rdy), 0);
        @(posedge rclk);
        #1 chk("R2 out_rdy after 3rd edge", 32'(out_rdy), 1);
        chk("R2 first word", 32'(r_data), 101);
      end else begin
        wr_try(WIDTH'(100 + k), 1, 0);
      end
      settle();
      chk("R7 alm_full_n fill", 32'(alm_full_n), 32'((DEPTH - k) > YTH));
      chk("R6 alm_empty_n fill", 32'(alm_empty_n), 32'(k > XTH));
      chk("R4 in_rdy fill", 32'(in_rdy), 32'(k < DEPTH));
      chk("R3 head word held", 32'(r_data), 101);
    end

    wr_try(16'hBEEF, 1, 0);
    settle();

    for (int j = 0; j < DEPTH; j++) begin
      chk("R3 drain order", 32'(r_data), 32'(101 + j));
      chk("R3 drain valid", 32'(out_rdy), 1);
      if (j == 3) begin
        rd_try(1, 1);
        chk("R5 deselected read ignored", 32'(r_data), 32'(101 + j));
      end
      rd_try(1, 0);
      settle();
      chk("R6 alm_empty_n drain", 32'(alm_empty_n), 32'((DEPTH - 1 - j) > XTH));
      chk("R7 alm_full_n drain", 32'(alm_full_n), 32'((j + 1) > YTH));
      chk("R4 in_rdy after reads", 32'(in_rdy), 1);
    end
    chk("R4 write while full dropped", 32'(out_rdy), 0);

    // retransmit
    do_reset();
    for (int i = 0; i < 5; i++) wr_try(WIDTH'(16'hA0 + i), 1, 0);
    settle();
    chk("R3 retransmit setup head", 32'(r_data), 32'h0A0);
    rd_try(1, 0);
    set_rt(1);
    chk("R8 word at mark", 32'(r_data), 32'h0A1);
    for (int i = 1; i < 4; i++) begin
      chk("R8 reads in mode", 32'(r_data), 32'(16'hA0 + i));
      rd_try(1, 0);
    end
    chk("R8 fourth word", 32'(r_data), 32'h0A4);
    mark_pulse();
    chk("R9 reload word", 32'(r_data), 32'h0A1);
    chk("R9 reload valid", 32'(out_rdy), 1);
    rd_try(1, 0);
    chk("R9 continues after mark", 32'(r_data), 32'h0A2);

    settle();
    for (int i = 0; i < 6; i++) wr_try(WIDTH'(16'hB0 + i), 1, 0);
    settle();
    chk("R10 in_rdy low at mark", 32'(in_rdy), 0);
    mark_pulse();
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < DEPTH; i++) begin
        chk("R10 protected sequence", 32'(r_data), (i < 4) ? 32'(16'hA1 + i) : 32'(16'hB0 + i - 4));
        rd_try(1, 0);
      end
      chk("R10 extra writes dropped", 32'(out_rdy), 0);
      mark_pulse();
      chk("R10 marked word intact", 32'(r_data), 32'h0A1);
    end
    for (int i = 0; i < DEPTH; i++) rd_try(1, 0);
    settle();
    chk("R10 space held while in mode", 32'(in_rdy), 0);

    set_rt(0);
    settle();
    settle();
    chk("R11 space released", 32'(in_rdy), 1);
    mark_pulse();
    chk("R11 reload ignored after exit", 32'(out_rdy), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule